// File: doc/BRIEF.md
# Programmable Two-Level Interrupt Priority Resolver

This block chooses one winner from six interrupt request lines, numbered 0 to 5. The lines are grouped in fixed pairs. Group A holds sources 3 and 5. Group B holds sources 0 and 2. Group C holds sources 1 and 4.

An 8-bit priority register can only be written. It holds two kinds of setting:
- a 3-bit code that ranks the three groups against each other;
- three swap bits, one per group, each of which decides which member of its pair wins.

A source competes only when its pending bit and its enable bit are both set. A group with no competing member is passed over, and the next group in rank order is examined.

The result is registered. It is a valid flag and the 3-bit number of the winning source. A surrounding interrupt controller reads this result to pick the vector to service. That controller owns the acknowledge and flag-clearing steps.

Top module: `irq_prio_resolver`

## Requirements
- R1: Source pairing is fixed: group A = {3,5}, group B = {0,2}, group C = {1,4}. A grant always names a source that was eligible in the cycle before.
- R2: The in-pair order is set by three register bits. Bit 5 = 0 makes 5 beat 3, and bit 5 = 1 makes 3 beat 5. Bit 2 = 0 makes 2 beat 0, and bit 2 = 1 makes 0 beat 2. Bit 1 = 0 makes 1 beat 4, and bit 1 = 1 makes 4 beat 1.
- R3: The group ranking code is {bit4, bit3, bit0}, with bit 4 as the MSB. The codes rank the groups as follows: 3'b010 A>B>C, 3'b011 A>C>B, 3'b110 B>A>C, 3'b100 B>C>A, 3'b001 C>A>B, 3'b101 C>B>A.
- R4: Codes 3'b000 and 3'b111 are reserved. While the register holds either of them, grant_valid stays 0 whatever is pending.
- R5: A source is eligible only when req_pending[i] and req_enable[i] are both 1. A pending source that is masked never wins.
- R6: A group with no eligible member is skipped. The best eligible member of the highest-ranked non-empty group wins, even if that member is not the preferred one of its pair.
- R7: The grant is registered. A change on req_pending or req_enable is seen at the outputs after exactly one rising clock edge. A register write takes effect at the edge that captures it, and so shows at the outputs one edge later.
- R8: grant_valid is 0 in the cycle after one in which no source was eligible.
- R9: While reset is active, and right after it, the register is 8'h00 and grant_valid and grant_id are 0.
- R10: A write is accepted only when cfg_we is 1 and bits 7 and 6 of cfg_wdata are both 0. Any other write leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Priority register write strobe |
| cfg_wdata | input | 8 | Priority register write data |
| req_pending | input | 6 | Pending request per source |
| req_enable | input | 6 | Enable mask per source |
| grant_valid | output | 1 | A winner exists |
| grant_id | output | 3 | Number of the winning source |

## Verification
The assertions assume three things:
- the request and enable vectors are stable around the rising clock edge;
- rst_n is asserted long enough to clear the register before any check matters;
- the eligibility seen at one edge is the eligibility the next grant is judged against.

The stimulus follows these assumptions. It changes pending, enable and the write port only on falling edges, and it keeps each pattern steady for at least two rising edges before sampling. It visits every ranking code, including the reserved ones. It also covers the cases where the preferred member of a pair is masked or missing.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int unsigned NUM_SRC = 6;
    localparam int unsigned SRC_W   = $clog2(NUM_SRC);
    localparam int unsigned NUM_GRP = 3;
    localparam int unsigned CFG_W   = 8;
    localparam int unsigned CODE_W  = 3;

    typedef logic [SRC_W-1:0] src_id_t;

    typedef enum logic [1:0] {
        GRP_A = 2'd0,
        GRP_B = 2'd1,
        GRP_C = 2'd2
    } grp_t;

    typedef struct packed {
        logic [CODE_W-1:0] order_code;
        logic              swap_a;
        logic              swap_b;
        logic              swap_c;
    } prio_cfg_t;

    typedef struct packed {
        logic ok;
        grp_t first;
        grp_t second;
        grp_t third;
    } grp_order_t;

    typedef struct packed {
        logic    valid;
        src_id_t id;
    } grant_t;

    // member that wins inside a group when its swap bit is 0
    function automatic src_id_t grp_primary(grp_t g);
        case (g)
            GRP_A:   return src_id_t'(5);
            GRP_B:   return src_id_t'(2);
            default: return src_id_t'(1);
        endcase
    endfunction

    // member that wins inside a group when its swap bit is 1
    function automatic src_id_t grp_alternate(grp_t g);
        case (g)
            GRP_A:   return src_id_t'(3);
            GRP_B:   return src_id_t'(0);
            default: return src_id_t'(4);
        endcase
    endfunction

    function automatic grp_order_t decode_order(logic [CODE_W-1:0] code);
        grp_order_t o;
        o = '{ok: 1'b1, first: GRP_A, second: GRP_B, third: GRP_C};
        case (code)
            3'b001:  begin o.first = GRP_C; o.second = GRP_A; o.third = GRP_B; end
            3'b010:  begin o.first = GRP_A; o.second = GRP_B; o.third = GRP_C; end
            3'b011:  begin o.first = GRP_A; o.second = GRP_C; o.third = GRP_B; end
            3'b100:  begin o.first = GRP_B; o.second = GRP_C; o.third = GRP_A; end
            3'b101:  begin o.first = GRP_C; o.second = GRP_B; o.third = GRP_A; end
            3'b110:  begin o.first = GRP_B; o.second = GRP_A; o.third = GRP_C; end
            default: o.ok = 1'b0;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/irq_prio_cfg.sv
module irq_prio_cfg
    import irq_prio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [CFG_W-1:0] wdata_i,
    output prio_cfg_t        cfg_o
);

    prio_cfg_t cfg_d, cfg_q;
    logic      accept;

    always_comb begin
        accept = we_i && (wdata_i[7:6] == 2'b00);
        cfg_d  = cfg_q;
        if (accept) begin
            cfg_d.order_code = {wdata_i[4], wdata_i[3], wdata_i[0]};
            cfg_d.swap_a     = wdata_i[5];
            cfg_d.swap_b     = wdata_i[2];
            cfg_d.swap_c     = wdata_i[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

    // R10
    rsvd_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && (wdata_i[7:6] != 2'b00)) |=> $stable(cfg_q));

endmodule

// File: rtl/irq_pair_pick.sv
module irq_pair_pick
    import irq_prio_pkg::*;
#(
    parameter src_id_t FAV_ID = src_id_t'(5),
    parameter src_id_t ALT_ID = src_id_t'(3)
) (
    input  logic [NUM_SRC-1:0] elig_i,
    input  logic               swap_i,
    output logic               any_o,
    output src_id_t            id_o
);

    src_id_t lead, trail;

    always_comb begin
        lead  = swap_i ? ALT_ID : FAV_ID;
        trail = swap_i ? FAV_ID : ALT_ID;
        any_o = elig_i[FAV_ID] | elig_i[ALT_ID];
        id_o  = elig_i[lead] ? lead : trail;
        // R1
        if (any_o) begin
            pair_member_chk: assert ((id_o == FAV_ID) || (id_o == ALT_ID));
            pair_elig_chk:   assert (elig_i[id_o]);
        end
    end

endmodule

// File: rtl/irq_group_arb.sv
module irq_group_arb
    import irq_prio_pkg::*;
(
    input  grp_order_t                     order_i,
    input  logic [NUM_GRP-1:0]             grp_any_i,
    input  logic [NUM_GRP-1:0][SRC_W-1:0]  grp_id_i,
    output logic                           valid_o,
    output src_id_t                        id_o
);

    grp_t               rank [NUM_GRP];
    logic [NUM_GRP-1:0] pick_mask;

    always_comb begin
        rank[0]   = order_i.first;
        rank[1]   = order_i.second;
        rank[2]   = order_i.third;
        pick_mask = '0;
        valid_o   = 1'b0;
        id_o      = '0;
        if (order_i.ok) begin
            for (int r = 0; r < NUM_GRP; r++) begin
                if (!valid_o && grp_any_i[rank[r]]) begin
                    valid_o         = 1'b1;
                    id_o            = grp_id_i[rank[r]];
                    pick_mask[rank[r]] = 1'b1;
                end
            end
        end
        // R6
        one_group_chk: assert ($onehot0(pick_mask));
    end

endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
    import irq_prio_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic [NUM_SRC-1:0] req_pending,
    input  logic [NUM_SRC-1:0] req_enable,
    output logic               grant_valid,
    output logic [SRC_W-1:0]   grant_id
);

    prio_cfg_t                     cfg;
    grp_order_t                    order;
    logic [NUM_SRC-1:0]            elig;
    logic [NUM_GRP-1:0]            swap_vec;
    logic [NUM_GRP-1:0]            grp_any;
    logic [NUM_GRP-1:0][SRC_W-1:0] grp_id;
    logic                          win_valid;
    src_id_t                       win_id;
    grant_t                        out_d, out_q;

    irq_prio_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .wdata_i (cfg_wdata),
        .cfg_o   (cfg)
    );

    assign elig     = req_pending & req_enable;
    assign order    = decode_order(cfg.order_code);
    assign swap_vec = {cfg.swap_c, cfg.swap_b, cfg.swap_a};

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_pair
        irq_pair_pick #(
            .FAV_ID (grp_primary(grp_t'(g))),
            .ALT_ID (grp_alternate(grp_t'(g)))
        ) u_pick (
            .elig_i (elig),
            .swap_i (swap_vec[g]),
            .any_o  (grp_any[g]),
            .id_o   (grp_id[g])
        );
    end

    irq_group_arb u_arb (
        .order_i   (order),
        .grp_any_i (grp_any),
        .grp_id_i  (grp_id),
        .valid_o   (win_valid),
        .id_o      (win_id)
    );

    always_comb begin
        out_d.valid = win_valid;
        out_d.id    = win_valid ? win_id : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign grant_valid = out_q.valid;
    assign grant_id    = out_q.id;

    // R4
    rsvd_code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !order.ok |=> !grant_valid);

    // R8
    none_elig_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (elig == '0) |=> !grant_valid);

    // R7
    elig_grants_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (order.ok && (elig != '0)) |=> grant_valid);

    // R5
    grant_was_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> ((($past(elig) >> grant_id) & 6'd1) != 6'd0));

endmodule

// File: tb/irq_prio_resolver_tb.sv
module irq_prio_resolver_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [5:0] req_pending = '0;
    logic [5:0] req_enable = '0;
    logic       grant_valid;
    logic [2:0] grant_id;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    irq_prio_resolver u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .req_pending (req_pending),
        .req_enable  (req_enable),
        .grant_valid (grant_valid),
        .grant_id    (grant_id)
    );

    // {cfg byte, pending, enable, exp valid, exp id}
    localparam int NV = 15;
    localparam logic [23:0] VEC [NV] = '{
        {8'h08, 6'h3F, 6'h3F, 1'b1, 3'd5},
        {8'h28, 6'h3F, 6'h3F, 1'b1, 3'd3},
        {8'h01, 6'h3F, 6'h3F, 1'b1, 3'd1},
        {8'h03, 6'h3F, 6'h3F, 1'b1, 3'd4},
        {8'h10, 6'h3F, 6'h3F, 1'b1, 3'd2},
        {8'h14, 6'h3F, 6'h3F, 1'b1, 3'd0},
        {8'h09, 6'h03, 6'h3F, 1'b1, 3'd1},
        {8'h11, 6'h28, 6'h3F, 1'b1, 3'd5},
        {8'h18, 6'h12, 6'h3F, 1'b1, 3'd1},
        {8'h18, 6'h3F, 6'h3A, 1'b1, 3'd5},
        {8'h00, 6'h3F, 6'h3F, 1'b0, 3'd0},
        {8'h19, 6'h3F, 6'h3F, 1'b0, 3'd0},
        {8'h08, 6'h00, 6'h3F, 1'b0, 3'd0},
        {8'h08, 6'h3F, 6'h08, 1'b1, 3'd3},
        {8'h08, 6'h3F, 6'h00, 1'b0, 3'd0}
    };

    function automatic string vec_tag(int i);
        case (i)
            0, 1, 2, 3, 4, 5: return "R2";
            6, 7, 8:          return "R6";
            9, 13:            return "R5";
            10, 11:           return "R4";
            default:          return "R8";
        endcase
    endfunction

    // independent reference: returns {valid, id}
    function automatic logic [3:0] model(logic [7:0] c, logic [5:0] p, logic [5:0] e);
        int ord [3];
        int best [3];
        int other [3];
        logic [5:0] el;
        el = p & e;
        case ({c[4], c[3], c[0]})
            3'd1: ord = '{2, 0, 1};
            3'd2: ord = '{0, 1, 2};
            3'd3: ord = '{0, 2, 1};
            3'd4: ord = '{1, 2, 0};
            3'd5: ord = '{2, 1, 0};
            3'd6: ord = '{1, 0, 2};
            default: return 4'd0;
        endcase
        best[0] = c[5] ? 3 : 5; other[0] = c[5] ? 5 : 3;
        best[1] = c[2] ? 0 : 2; other[1] = c[2] ? 2 : 0;
        best[2] = c[1] ? 4 : 1; other[2] = c[1] ? 1 : 4;
        for (int k = 0; k < 3; k++) begin
            if (el[best[ord[k]]])  return {1'b1, 3'(best[ord[k]])};
            if (el[other[ord[k]]]) return {1'b1, 3'(other[ord[k]])};
        end
        return 4'd0;
    endfunction

    task automatic check(string tag, logic ev, logic [2:0] eid);
        n_run++;
        if (grant_valid !== ev || (ev && grant_id !== eid)) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b id=%0d, expected valid=%0b id=%0d",
                     tag, grant_valid, grant_id, ev, eid);
        end
    endtask

    task automatic apply(logic [7:0] c, logic [5:0] p, logic [5:0] e);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = c; req_pending = p; req_enable = e;
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        // R9: reset state with everything pending
        req_pending = 6'h3F; req_enable = 6'h3F;
        repeat (3) @(negedge clk);
        check("R9 in reset", 1'b0, 3'd0);
        rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R9 after reset (code 000)", 1'b0, 3'd0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][23:16], VEC[i][15:10], VEC[i][9:4]);
            check(vec_tag(i), VEC[i][3], VEC[i][2:0]);
        end

        // R3: every code, several patterns, against the model
        for (int code = 0; code < 8; code++) begin
            for (int pat = 0; pat < 4; pat++) begin
                logic [7:0] c;
                logic [5:0] p;
                logic [3:0] m;
                c = {2'b00, pat[0], 3'(code) >> 1 & 3'b100 ? 1'b1 : 1'b0,
                     code[1], pat[1], pat[0] ^ pat[1], code[0]};
                c[4] = code[2];
                p = (pat == 0) ? 6'h3F : (pat == 1) ? 6'h15 : (pat == 2) ? 6'h2A : 6'h19;
                m = model(c, p, 6'h3F);
                apply(c, p, 6'h3F);
                check("R3 code sweep", m[3], m[2:0]);
            end
        end

        // R1: swapped pairs, preferred absent, with model
        apply(8'h2E, 6'h3F, 6'h15);
        check("R1 pairing", 1'b1, 3'd0);

        // R7: one-edge latency on request change
        apply(8'h08, 6'h00, 6'h3F);
        @(negedge clk);
        req_pending = 6'h04;
        #1;
        check("R7 before edge", 1'b0, 3'd0);
        @(negedge clk);
        check("R7 after one edge", 1'b1, 3'd2);

        // R7: write takes effect at capture edge, seen one edge later
        req_pending = 6'h3F;
        @(negedge clk);
        check("R7 baseline", 1'b1, 3'd5);
        cfg_we = 1'b1; cfg_wdata = 8'h10;
        @(negedge clk);
        cfg_we = 1'b0;
        check("R7 write not yet visible", 1'b1, 3'd5);
        @(negedge clk);
        check("R7 write visible", 1'b1, 3'd2);

        // R10: write with reserved bits set is dropped
        apply(8'h08, 6'h3F, 6'h3F);
        apply(8'hC9, 6'h3F, 6'h3F);
        check("R10 reserved bits", 1'b1, 3'd5);
        apply(8'h40, 6'h3F, 6'h3F);
        check("R10 bit6 only", 1'b1, 3'd5);
        // R10: data without strobe is ignored
        @(negedge clk);
        cfg_wdata = 8'h00;
        repeat (2) @(negedge clk);
        check("R10 no strobe", 1'b1, 3'd5);

        // R9: reset mid-run clears register
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset mid-run", 1'b0, 3'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 register cleared", 1'b0, 3'd0);

        finish_run();
    end

endmodule